// File: doc/BRIEF.md
# Highway and Side-Street Junction Light Controller

This block sequences the lamps at a crossing of a busy highway and a quiet side street. In its rest phase the highway shows green and the side street red, and it stays there for as long as no car waits on the side street. A waiting side-street car starts a handover. If highway traffic is present, the controller first lets it clear, but never for longer than a capped number of seconds. The highway then shows a blinking green, and after that both roads show yellow. The side street then gets green for a fixed interval, then yellow, and the junction returns to rest.

All timing is counted in pulses of a one-second enable input, `tick_en`, that comes from a divider outside the block. Every phase length is a parameter, so short timings can be used when needed. The lamp codes and a separate blink-lamp signal are registered, so they change on the same edge as the internal phase.

Top module: `junction_light_ctrl`

## Requirements
- R1: After a synchronous active-high `rst`, `main_light` shows green, `side_light` shows red and `main_lamp_on` is 1. These values hold for any number of ticks while `side_car` stays 0.
- R2: Each light output uses a 2-bit code: 2'b00 red, 2'b01 yellow, 2'b10 green, 2'b11 blinking green.
- R3: In the rest phase, if `side_car`=1 and `main_car`=0 are sampled at a clock edge, `main_light` reads 2'b11 straight after that edge.
- R4: In the rest phase, if `side_car`=1 and `main_car`=1 are sampled, the highway stays green and the side street red (the clearing phase). The blinking green starts on the first edge at which `main_car`=0 is sampled.
- R5: The clearing phase lasts at most MAX_WAIT ticks (default 25). If `main_car` stays 1, the blinking green starts on the edge that samples the MAX_WAIT-th tick counted after entry.
- R6: Blinking green lasts WARN_TICKS ticks (default 3). `main_lamp_on` is 1 on entry and toggles at every tick counted inside the phase.
- R7: After the blinking green, both lights show yellow for AMBER_TICKS ticks (default 2).
- R8: After the both-yellow phase, `main_light` is red and `side_light` green for SIDE_GO_TICKS ticks (default 10).
- R9: After the side-street green, `side_light` shows yellow and `main_light` red for SIDE_AMBER_TICKS ticks (default 2). The controller then returns to the rest phase.
- R10: `side_car` has no effect outside the rest phase. A request held through a handover is acted on only once the rest phase has been reached again. A tick sampled on the edge that enters a phase is not counted.
- R11: The two roads never show green or blinking green at the same time, and `main_lamp_on` is 0 only while the highway shows blinking green.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-second enable pulse, one clock wide |
| main_car | input | 1 | Highway car present |
| side_car | input | 1 | Side-street car present |
| main_light | output | 2 | Highway lamp code |
| side_light | output | 2 | Side-street lamp code |
| main_lamp_on | output | 1 | Highway lamp lit (toggles during blinking green) |

## Verification
The assertions assume that `tick_en` is a synchronous pulse and that the car inputs are stable at the clock edge. They place no limit on how often ticks arrive or on how long cars stay present. The random stimulus changes inputs only between edges and sometimes raises `tick_en` on consecutive cycles. It holds `main_car` for long stretches so that the wait cap is reached, and it raises `side_car` at arbitrary points, including in the middle of a handover. Directed sequences cover an idle rest phase, an immediate handover and a wait that hits the cap.

// File: rtl/tl_pkg.sv
package tl_pkg;

  typedef enum logic [1:0] {
    LT_RED   = 2'b00,
    LT_YEL   = 2'b01,
    LT_GRN   = 2'b10,
    LT_BLINK = 2'b11
  } lamp_code_t;

  typedef enum logic [2:0] {
    PH_REST       = 3'd0,
    PH_CLEAR      = 3'd1,
    PH_WARN       = 3'd2,
    PH_AMBER      = 3'd3,
    PH_SIDE_GO    = 3'd4,
    PH_SIDE_AMBER = 3'd5
  } phase_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tl_dwell_counter.sv
module tl_dwell_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic             tick_en,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (run && tick_en) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last = run && tick_en && (cnt_q == limit - 1'b1);

  // R5
  dwell_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q < limit));

endmodule

// File: rtl/tl_phase_fsm.sv
module tl_phase_fsm
  import tl_pkg::*;
#(
  parameter int CNT_W            = 5,
  parameter int MAX_WAIT         = 25,
  parameter int WARN_TICKS       = 3,
  parameter int AMBER_TICKS      = 2,
  parameter int SIDE_GO_TICKS    = 10,
  parameter int SIDE_AMBER_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             main_car,
  input  logic             side_car,
  input  logic             last,
  output phase_t           phase_q,
  output phase_t           phase_nxt,
  output logic             run,
  output logic             clear,
  output logic [CNT_W-1:0] limit
);

  always_comb begin
    phase_nxt = phase_q;
    unique case (phase_q)
      PH_REST:       if (side_car) phase_nxt = main_car ? PH_CLEAR : PH_WARN;
      PH_CLEAR:      if (!main_car || last) phase_nxt = PH_WARN;
      PH_WARN:       if (last) phase_nxt = PH_AMBER;
      PH_AMBER:      if (last) phase_nxt = PH_SIDE_GO;
      PH_SIDE_GO:    if (last) phase_nxt = PH_SIDE_AMBER;
      PH_SIDE_AMBER: if (last) phase_nxt = PH_REST;
      default:       phase_nxt = PH_REST;
    endcase
  end

  always_comb begin
    unique case (phase_q)
      PH_CLEAR:      limit = CNT_W'(MAX_WAIT);
      PH_WARN:       limit = CNT_W'(WARN_TICKS);
      PH_AMBER:      limit = CNT_W'(AMBER_TICKS);
      PH_SIDE_GO:    limit = CNT_W'(SIDE_GO_TICKS);
      PH_SIDE_AMBER: limit = CNT_W'(SIDE_AMBER_TICKS);
      default:       limit = CNT_W'(1);
    endcase
  end

  assign run   = (phase_q != PH_REST);
  assign clear = (phase_nxt != phase_q);

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_REST;
    else     phase_q <= phase_nxt;
  end

  // R10
  leave_rest_on_request_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_REST && $past(phase_q) == PH_REST) |-> $past(side_car));

  // R4
  clear_ends_on_free_road_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_CLEAR && !main_car) |=> (phase_q == PH_WARN));

  // R9
  phase_order_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q != $past(phase_q)) |->
      ((phase_q == PH_WARN && ($past(phase_q) == PH_REST || $past(phase_q) == PH_CLEAR)) ||
       (phase_q == PH_CLEAR && $past(phase_q) == PH_REST) ||
       (phase_q == PH_AMBER && $past(phase_q) == PH_WARN) ||
       (phase_q == PH_SIDE_GO && $past(phase_q) == PH_AMBER) ||
       (phase_q == PH_SIDE_AMBER && $past(phase_q) == PH_SIDE_GO) ||
       (phase_q == PH_REST && $past(phase_q) == PH_SIDE_AMBER)));

endmodule

// File: rtl/tl_lamp_driver.sv
module tl_lamp_driver
  import tl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  input  phase_t     phase_q,
  input  phase_t     phase_nxt,
  output logic [1:0] main_q,
  output logic [1:0] side_q,
  output logic       lamp_q
);

  lamp_code_t main_d, side_d;
  logic       lamp_d;

  always_comb begin
    unique case (phase_nxt)
      PH_REST, PH_CLEAR: begin main_d = LT_GRN;   side_d = LT_RED; end
      PH_WARN:           begin main_d = LT_BLINK; side_d = LT_RED; end
      PH_AMBER:          begin main_d = LT_YEL;   side_d = LT_YEL; end
      PH_SIDE_GO:        begin main_d = LT_RED;   side_d = LT_GRN; end
      PH_SIDE_AMBER:     begin main_d = LT_RED;   side_d = LT_YEL; end
      default:           begin main_d = LT_RED;   side_d = LT_RED; end
    endcase
  end

  always_comb begin
    if (phase_nxt != PH_WARN)      lamp_d = 1'b1;
    else if (phase_q != PH_WARN)   lamp_d = 1'b1;
    else if (tick_en)              lamp_d = ~lamp_q;
    else                           lamp_d = lamp_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      main_q <= LT_GRN;
      side_q <= LT_RED;
      lamp_q <= 1'b1;
    end else begin
      main_q <= main_d;
      side_q <= side_d;
      lamp_q <= lamp_d;
    end
  end

  // R11
  no_dual_green_chk: assert property (@(posedge clk) disable iff (rst)
    !((main_q == LT_GRN || main_q == LT_BLINK) && side_q == LT_GRN));

  // R11
  dark_only_blinking_chk: assert property (@(posedge clk) disable iff (rst)
    !lamp_q |-> (main_q == LT_BLINK));

  // R7
  side_go_after_amber_chk: assert property (@(posedge clk) disable iff (rst)
    (side_q == LT_GRN && $past(side_q) != LT_GRN) |->
      ($past(main_q) == LT_YEL && $past(side_q) == LT_YEL));

endmodule

// File: rtl/junction_light_ctrl.sv
module junction_light_ctrl
  import tl_pkg::*;
#(
  parameter int MAX_WAIT         = 25,
  parameter int WARN_TICKS       = 3,
  parameter int AMBER_TICKS      = 2,
  parameter int SIDE_GO_TICKS    = 10,
  parameter int SIDE_AMBER_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  input  logic       main_car,
  input  logic       side_car,
  output logic [1:0] main_light,
  output logic [1:0] side_light,
  output logic       main_lamp_on
);

  localparam int LONGEST = max_of(max_of(MAX_WAIT, WARN_TICKS),
                                  max_of(max_of(AMBER_TICKS, SIDE_GO_TICKS), SIDE_AMBER_TICKS));
  localparam int CNT_W   = $clog2(LONGEST + 1);

  phase_t           phase_q, phase_nxt;
  logic             run, clear, last;
  logic [CNT_W-1:0] limit;

  tl_phase_fsm #(
    .CNT_W(CNT_W), .MAX_WAIT(MAX_WAIT), .WARN_TICKS(WARN_TICKS),
    .AMBER_TICKS(AMBER_TICKS), .SIDE_GO_TICKS(SIDE_GO_TICKS),
    .SIDE_AMBER_TICKS(SIDE_AMBER_TICKS)
  ) u_fsm (
    .clk(clk), .rst(rst), .main_car(main_car), .side_car(side_car),
    .last(last), .phase_q(phase_q), .phase_nxt(phase_nxt),
    .run(run), .clear(clear), .limit(limit)
  );

  tl_dwell_counter #(.CNT_W(CNT_W)) u_dwell (
    .clk(clk), .rst(rst), .clear(clear), .run(run),
    .tick_en(tick_en), .limit(limit), .last(last)
  );

  tl_lamp_driver u_lamps (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .phase_q(phase_q), .phase_nxt(phase_nxt),
    .main_q(main_light), .side_q(side_light), .lamp_q(main_lamp_on)
  );

endmodule

// File: tb/junction_light_ctrl_bench.sv
module junction_light_ctrl_bench;

  localparam int T_WAIT = 25, T_WARN = 3, T_AMB = 2, T_GO = 10, T_SAMB = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0, main_car = 1'b0, side_car = 1'b0;
  logic [1:0] main_light, side_light;
  logic main_lamp_on;

  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  junction_light_ctrl #(
    .MAX_WAIT(T_WAIT), .WARN_TICKS(T_WARN), .AMBER_TICKS(T_AMB),
    .SIDE_GO_TICKS(T_GO), .SIDE_AMBER_TICKS(T_SAMB)
  ) u_junction_light_ctrl (
    .clk(clk), .rst(rst), .tick_en(tick_en), .main_car(main_car), .side_car(side_car),
    .main_light(main_light), .side_light(side_light), .main_lamp_on(main_lamp_on)
  );

  // Reference model of the requirements: 0 rest, 1 clearing, 2 blink,
  // 3 both yellow, 4 side green, 5 side yellow.
  int  m_ph = 0, m_cnt = 0, m_nx;
  bit  m_lamp = 1'b1;

  function automatic int dur(input int ph);
    case (ph)
      1: return T_WAIT;
      2: return T_WARN;
      3: return T_AMB;
      4: return T_GO;
      default: return T_SAMB;
    endcase
  endfunction

  function automatic logic [1:0] exp_main(input int ph);
    case (ph)
      0, 1: return 2'b10;
      2: return 2'b11;
      3: return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] exp_side(input int ph);
    case (ph)
      3, 5: return 2'b01;
      4: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  function automatic string tag_of(input int ph);
    case (ph)
      0: return "R1";
      1: return "R4";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ph <= 0; m_cnt <= 0; m_lamp <= 1'b1;
    end else begin
      m_nx = m_ph;
      case (m_ph)
        0: if (side_car) m_nx = main_car ? 1 : 2;
        1: if (!main_car || (tick_en && m_cnt == T_WAIT - 1)) m_nx = 2;
        default: if (tick_en && m_cnt == dur(m_ph) - 1) m_nx = (m_ph == 5) ? 0 : m_ph + 1;
      endcase
      if (m_nx != m_ph) m_cnt <= 0;
      else if (m_ph != 0 && tick_en) m_cnt <= m_cnt + 1;
      if (m_nx == 2) m_lamp <= (m_ph == 2) ? (tick_en ? !m_lamp : m_lamp) : 1'b1;
      else m_lamp <= 1'b1;
      m_ph <= m_nx;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R11 and per-phase comparison against the model
  task automatic compare_model();
    check(main_light == exp_main(m_ph), tag_of(m_ph), main_light, exp_main(m_ph));
    check(side_light == exp_side(m_ph), tag_of(m_ph), side_light, exp_side(m_ph));
    check(main_lamp_on == m_lamp, "R6", main_lamp_on, m_lamp);
    check(!(main_light[1] && side_light == 2'b10), "R11", {main_light, side_light}, 0);
  endtask

  task automatic step(input bit t, input bit m, input bit s);
    tick_en = t; main_car = m; side_car = s;
    @(posedge clk);
    @(negedge clk);
    compare_model();
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(main_light == 2'b10, "R1", main_light, 2'b10);
    check(side_light == 2'b00, "R1", side_light, 2'b00);
    check(main_lamp_on == 1'b1, "R1", main_lamp_on, 1);
    // R1 idle: ticks and highway cars, no side car
    for (int i = 0; i < 40; i++) step(i % 2 == 0, i % 3 == 0, 1'b0);
    check(main_light == 2'b10 && side_light == 2'b00, "R1", {main_light, side_light}, 4'b1000);

    // R3 immediate handover, R2 blink code 2'b11
    step(1'b0, 1'b0, 1'b1);
    check(main_light == 2'b11, "R3", main_light, 2'b11);
    // R10 side request during handover ignored; run through with ticks
    for (int i = 0; i < 60; i++) step(i % 3 == 0, 1'b0, 1'b1);
    // R10 release and return to rest
    for (int i = 0; i < 60; i++) step(1'b1, 1'b0, 1'b0);
    check(main_light == 2'b10 && side_light == 2'b00, "R10", {main_light, side_light}, 4'b1000);

    // R5 wait cap with the highway car held
    step(1'b0, 1'b1, 1'b1);
    check(main_light == 2'b10, "R4", main_light, 2'b10);
    for (int i = 0; i < T_WAIT - 1; i++) begin
      step(1'b1, 1'b1, 1'b0);
      step(1'b0, 1'b1, 1'b0);
    end
    check(main_light == 2'b10, "R5", main_light, 2'b10);
    step(1'b1, 1'b1, 1'b0);
    check(main_light == 2'b11, "R5", main_light, 2'b11);
    // R6 blinking lamp toggles per tick
    step(1'b1, 1'b1, 1'b0);
    check(main_lamp_on == 1'b0, "R6", main_lamp_on, 0);
    step(1'b1, 1'b1, 1'b0);
    check(main_lamp_on == 1'b1, "R6", main_lamp_on, 1);
    step(1'b1, 1'b1, 1'b0);
    check(main_light == 2'b01 && side_light == 2'b01, "R7", {main_light, side_light}, 4'b0101);
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 1'b0);

    // R4 early release of the highway
    step(1'b0, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    check(main_light == 2'b11, "R4", main_light, 2'b11);

    // random traffic
    for (int i = 0; i < 6000; i++) begin
      bit t, s;
      t = ($urandom % 4) == 0;
      s = ($urandom % 16) == 0;
      if (($urandom % 40) == 0) main_car = ~main_car;
      step(t, main_car, s);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule